// File: doc/BRIEF.md
# Multi-Channel Window Threshold Monitor

This block sits beside a multi-channel ADC sequencer and inspects every conversion result it delivers. A result arrives as a valid strobe with a channel number and a 10-bit value. If the channel is enabled and the value lies outside a window bounded by one shared upper and one shared lower threshold, the block latches a per-channel event bit and a global watchdog flag. The global flag can drive an interrupt output when the interrupt enable is set.

Software programs the block through a byte-wide register port with a write strobe, a write address, write data and a combinational read address and data. Each 10-bit threshold is split over two byte registers, one holding bits 9:2 and the other bits 1:0 in its lowest positions. Up to 10 channels are covered by an enable mask and a sticky event mask, each split over two byte registers. Event bits and the global flag stay set until software writes a zero to them.

Top module: `range_watch`

## Requirements
- R1: Address 1 holds upper threshold bits 9:2 and address 2 holds bits 1:0 in data bits 1:0; both read back as written, with the unused bits of address 2 reading zero.
- R2: Address 3 holds lower threshold bits 9:2 and address 4 holds bits 1:0 in data bits 1:0, with the same read-back behaviour as R1.
- R3: Address 5 bit i enables channel i for channels 0 to 7; address 6 bits 1:0 enable channels 8 and 9; both read back as written, unused bits zero.
- R4: A valid result on an enabled channel whose value is above the upper threshold or below the lower threshold sets that channel's event bit, visible on chan_hit and at status addresses 7 (channels 0 to 7) and 8 (channels 8 and 9 in bits 1:0) from the clock edge that samples the result.
- R5: A result equal to the upper or to the lower threshold is inside the window and sets no event bit and no flag.
- R6: Any event sets the global flag, visible on wd_flag and as bit 6 of the control byte at address 0; wd_irq is high exactly when the flag is set and control bit 4 (interrupt enable) is one.
- R7: Writing a zero to a status bit clears it and writing a one leaves it unchanged; writing control bit 6 as zero clears the global flag and as one leaves it unchanged; an event in the same cycle as a clear leaves the bit set.
- R8: Results on channels whose enable bit is zero, or with channel numbers 10 and above, change no event bit and no flag.
- R9: After reset the upper threshold is all ones, the lower threshold zero, and the enables, event bits, flag and interrupt enable are zero.
- R10: Event bits and the global flag remain set across later in-window results until software clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| res_valid | input | 1 | Conversion result valid |
| res_chan | input | 4 | Channel number of the result |
| res_value | input | 10 | Conversion result value |
| chan_hit | output | 10 | Sticky per-channel event bits |
| wd_flag | output | 1 | Global watchdog flag |
| wd_irq | output | 1 | Interrupt request |

## Verification
Every result and register write is registered once, so chan_hit, wd_flag and wd_irq change at the clock edge that samples the stimulus and the read port reflects the new state in the same cycle, with no extra latency. The bench drives each stimulus half a cycle before that edge, queues the predicted outputs in the same step, and its monitor compares them two nanoseconds after the edge. Register reads are combinational and are compared one nanosecond after the read address is set, at a point where no edge intervenes.

// File: rtl/range_watch_pkg.sv
package range_watch_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_UP_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_UP_LO = 4'd2;
    localparam logic [ADDR_W-1:0] A_DN_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_DN_LO = 4'd4;
    localparam logic [ADDR_W-1:0] A_EN_LO = 4'd5;
    localparam logic [ADDR_W-1:0] A_EN_HI = 4'd6;
    localparam logic [ADDR_W-1:0] A_ST_LO = 4'd7;
    localparam logic [ADDR_W-1:0] A_ST_HI = 4'd8;

    localparam int FLAG_BIT = 6;
    localparam int IE_BIT   = 4;

endpackage

// File: rtl/range_watch_cmp.sv
module range_watch_cmp #(
    parameter int NCH = 10,
    parameter int RW  = 10,
    parameter int CW  = 4
) (
    input  logic           valid,
    input  logic [CW-1:0]  chan,
    input  logic [RW-1:0]  value,
    input  logic [RW-1:0]  upper,
    input  logic [RW-1:0]  lower,
    input  logic [NCH-1:0] enable,
    output logic [NCH-1:0] event_vec
);
    logic outside;
    assign outside = (value > upper) || (value < lower);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign event_vec[i] = valid && outside && enable[i] && (chan == CW'(i));
    end
endmodule

// File: rtl/range_watch_rdmux.sv
module range_watch_rdmux
    import range_watch_pkg::*;
#(
    parameter int NCH = 10,
    parameter int RW  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [RW-1:0]     upper,
    input  logic [RW-1:0]     lower,
    input  logic [NCH-1:0]    enable,
    input  logic [NCH-1:0]    hit,
    input  logic              flag,
    input  logic              ie,
    output logic [7:0]        data
);
    localparam int LOB = RW - 8;

    logic [7:0] en_lo, en_hi, st_lo, st_hi;

    always_comb begin
        en_lo = '0;
        en_hi = '0;
        st_lo = '0;
        st_hi = '0;
        for (int i = 0; i < NCH; i++) begin
            if (i < 8) begin
                en_lo[i % 8] = enable[i];
                st_lo[i % 8] = hit[i];
            end else begin
                en_hi[i % 8] = enable[i];
                st_hi[i % 8] = hit[i];
            end
        end
    end

    always_comb begin
        data = '0;
        case (addr)
            A_CTRL: begin
                data[FLAG_BIT] = flag;
                data[IE_BIT]   = ie;
            end
            A_UP_HI: data = upper[RW-1:LOB];
            A_UP_LO: data[LOB-1:0] = upper[LOB-1:0];
            A_DN_HI: data = lower[RW-1:LOB];
            A_DN_LO: data[LOB-1:0] = lower[LOB-1:0];
            A_EN_LO: data = en_lo;
            A_EN_HI: data = en_hi;
            A_ST_LO: data = st_lo;
            A_ST_HI: data = st_hi;
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/range_watch.sv
module range_watch
    import range_watch_pkg::*;
#(
    parameter int NCH = 10,
    parameter int RW  = 10,
    parameter int CW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              res_valid,
    input  logic [CW-1:0]     res_chan,
    input  logic [RW-1:0]     res_value,
    output logic [NCH-1:0]    chan_hit,
    output logic              wd_flag,
    output logic              wd_irq
);
    localparam int LOB = RW - 8;

    typedef struct packed {
        logic [RW-1:0]  upper;
        logic [RW-1:0]  lower;
        logic [NCH-1:0] enable;
        logic [NCH-1:0] hit;
        logic           flag;
        logic           ie;
    } state_t;

    state_t st_d, st_q;
    logic [NCH-1:0] evt;

    logic [RW-1:0]  upper_w, lower_w;
    logic [NCH-1:0] enable_w;
    assign upper_w  = st_q.upper;
    assign lower_w  = st_q.lower;
    assign enable_w = st_q.enable;

    range_watch_cmp #(.NCH(NCH), .RW(RW), .CW(CW)) u_cmp (
        .valid     (res_valid),
        .chan      (res_chan),
        .value     (res_value),
        .upper     (st_q.upper),
        .lower     (st_q.lower),
        .enable    (st_q.enable),
        .event_vec (evt)
    );

    range_watch_rdmux #(.NCH(NCH), .RW(RW)) u_rd (
        .addr   (rd_addr),
        .upper  (st_q.upper),
        .lower  (st_q.lower),
        .enable (st_q.enable),
        .hit    (st_q.hit),
        .flag   (st_q.flag),
        .ie     (st_q.ie),
        .data   (rd_data)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    st_d.ie = wr_data[IE_BIT];
                    if (!wr_data[FLAG_BIT]) st_d.flag = 1'b0;
                end
                A_UP_HI: st_d.upper[RW-1:LOB] = wr_data;
                A_UP_LO: st_d.upper[LOB-1:0]  = wr_data[LOB-1:0];
                A_DN_HI: st_d.lower[RW-1:LOB] = wr_data;
                A_DN_LO: st_d.lower[LOB-1:0]  = wr_data[LOB-1:0];
                A_EN_LO: begin
                    for (int i = 0; i < NCH; i++)
                        if (i < 8) st_d.enable[i] = wr_data[i % 8];
                end
                A_EN_HI: begin
                    for (int i = 0; i < NCH; i++)
                        if (i >= 8) st_d.enable[i] = wr_data[i % 8];
                end
                A_ST_LO: begin
                    for (int i = 0; i < NCH; i++)
                        if (i < 8 && !wr_data[i % 8]) st_d.hit[i] = 1'b0;
                end
                A_ST_HI: begin
                    for (int i = 0; i < NCH; i++)
                        if (i >= 8 && !wr_data[i % 8]) st_d.hit[i] = 1'b0;
                end
                default: ;
            endcase
        end
        st_d.hit = st_d.hit | evt;
        if (|evt) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.upper  <= '1;
            st_q.lower  <= '0;
            st_q.enable <= '0;
            st_q.hit    <= '0;
            st_q.flag   <= 1'b0;
            st_q.ie     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_hit = st_q.hit;
    assign wd_flag  = st_q.flag;
    assign wd_irq   = st_q.flag & st_q.ie;
endmodule

// File: rtl/range_watch_chk.sv
module range_watch_chk #(
    parameter int NCH = 10,
    parameter int RW  = 10,
    parameter int CW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic           res_valid,
    input logic [CW-1:0]  res_chan,
    input logic [RW-1:0]  res_value,
    input logic [RW-1:0]  upper,
    input logic [RW-1:0]  lower,
    input logic [NCH-1:0] enable,
    input logic [NCH-1:0] chan_hit,
    input logic           wd_flag,
    input logic           wd_irq
);
    localparam int EW = 1 << CW;

    logic [EW-1:0] en_w, hit_w;
    logic          on_chan, out_win, is_evt;
    assign en_w    = EW'(enable);
    assign hit_w   = EW'(chan_hit);
    assign on_chan = (32'(res_chan) < NCH) && en_w[res_chan];
    assign out_win = (res_value > upper) || (res_value < lower);
    assign is_evt  = res_valid && on_chan && out_win;

    // R4
    evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_evt |=> hit_w[$past(res_chan)]);

    // R6
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_evt |=> wd_flag);

    // R6
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> wd_flag);

    // R8
    off_chan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(res_valid && on_chan)) |=> ($stable(chan_hit) && $stable(wd_flag)));

    // R10
    sticky_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((chan_hit & $past(chan_hit)) == $past(chan_hit)));
endmodule

bind range_watch range_watch_chk #(.NCH(NCH), .RW(RW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .res_valid (res_valid),
    .res_chan  (res_chan),
    .res_value (res_value),
    .upper     (upper_w),
    .lower     (lower_w),
    .enable    (enable_w),
    .chan_hit  (chan_hit),
    .wd_flag   (wd_flag),
    .wd_irq    (wd_irq)
);

// File: tb/range_watch_test.sv
`timescale 1ns/1ps
module range_watch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       res_valid = 1'b0;
    logic [3:0] res_chan = '0;
    logic [9:0] res_value = '0;
    logic [9:0] chan_hit;
    logic       wd_flag, wd_irq;

    always #5 clk = ~clk;

    range_watch uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .res_valid(res_valid), .res_chan(res_chan), .res_value(res_value),
        .chan_hit(chan_hit), .wd_flag(wd_flag), .wd_irq(wd_irq)
    );

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [9:0] hit;
        logic       flag;
        logic       irq;
        string      req;
    } exp_t;
    exp_t sb[$];

    // bench model of register state
    logic [9:0] m_up = 10'h3FF, m_dn = '0, m_en = '0, m_hit = '0;
    logic       m_flag = 1'b0, m_ie = 1'b0;

    // driver: one cycle of stimulus, expected outputs pushed to the scoreboard
    task automatic step(input logic w, input logic [3:0] a, input logic [7:0] d,
                        input logic v, input logic [3:0] ch, input logic [9:0] val,
                        input string req);
        logic ev;
        exp_t e;
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d;
        res_valid = v; res_chan = ch; res_value = val;
        ev = v && (ch < 10) && m_en[ch] && ((val > m_up) || (val < m_dn));
        if (w) begin
            case (a)
                4'd0: begin m_ie = d[4]; if (!d[6]) m_flag = 1'b0; end
                4'd1: m_up[9:2] = d;
                4'd2: m_up[1:0] = d[1:0];
                4'd3: m_dn[9:2] = d;
                4'd4: m_dn[1:0] = d[1:0];
                4'd5: m_en[7:0] = d;
                4'd6: m_en[9:8] = d[1:0];
                4'd7: m_hit[7:0] = m_hit[7:0] & d;
                4'd8: m_hit[9:8] = m_hit[9:8] & d[1:0];
                default: ;
            endcase
        end
        if (ev) begin m_hit[ch] = 1'b1; m_flag = 1'b1; end
        e.hit = m_hit; e.flag = m_flag; e.irq = m_flag & m_ie; e.req = req;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; res_valid = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
        step(1'b1, a, d, 1'b0, 4'd0, 10'd0, req);
    endtask

    task automatic res(input logic [3:0] ch, input logic [9:0] val, input string req);
        step(1'b0, 4'd0, 8'd0, 1'b1, ch, val, req);
    endtask

    // monitor: compares outputs 2 ns after the edge that sampled the stimulus
    always @(posedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            #2;
            e = sb.pop_front();
            total++;
            if (chan_hit !== e.hit || wd_flag !== e.flag || wd_irq !== e.irq) begin
                bad++;
                $display("FAIL %s: hit=%h flag=%b irq=%b expected hit=%h flag=%b irq=%b",
                         e.req, chan_hit, wd_flag, wd_irq, e.hit, e.flag, e.irq);
            end
        end
    end

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s: addr %0d read %h expected %h", req, a, rd_data, exp);
        end
    endtask

    task automatic rd_all(input string req);
        rd_chk(4'd0, {1'b0, m_flag, 1'b0, m_ie, 4'b0}, req);
        rd_chk(4'd1, m_up[9:2], req);
        rd_chk(4'd2, {6'b0, m_up[1:0]}, req);
        rd_chk(4'd3, m_dn[9:2], req);
        rd_chk(4'd4, {6'b0, m_dn[1:0]}, req);
        rd_chk(4'd5, m_en[7:0], req);
        rd_chk(4'd6, {6'b0, m_en[9:8]}, req);
        rd_chk(4'd7, m_hit[7:0], req);
        rd_chk(4'd8, {6'b0, m_hit[9:8]}, req);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        rd_chk(4'd1, 8'hFF, "R9 upper high");
        rd_chk(4'd2, 8'h03, "R9 upper low");
        rd_all("R9 reset");
        total++;
        if (chan_hit !== '0 || wd_flag !== 1'b0 || wd_irq !== 1'b0) begin
            bad++;
            $display("FAIL R9: hit=%h flag=%b irq=%b expected 0 0 0", chan_hit, wd_flag, wd_irq);
        end
        // R1 R2: upper 800, lower 300
        wr(4'd1, 8'd200, "R1 write upper high");
        wr(4'd2, 8'hFC, "R1 write upper low");
        wr(4'd3, 8'd75, "R2 write lower high");
        wr(4'd4, 8'h00, "R2 write lower low");
        // R3: enable channels 4 and 9
        wr(4'd5, 8'h10, "R3 enable low");
        wr(4'd6, 8'hFE, "R3 enable high");
        rd_all("R1 R2 R3 readback");
        // R5 inside and boundaries
        res(4'd4, 10'd500, "R5 inside");
        res(4'd4, 10'd800, "R5 equal upper");
        res(4'd4, 10'd300, "R5 equal lower");
        // R8 disabled and out-of-range channels
        res(4'd2, 10'd900, "R8 disabled channel");
        res(4'd12, 10'd900, "R8 channel 12");
        res(4'd15, 10'd0, "R8 channel 15");
        rd_all("R8 status untouched");
        // R4 R6 above upper
        res(4'd4, 10'd801, "R4 above upper ch4");
        res(4'd4, 10'd500, "R10 sticky after inside");
        res(4'd9, 10'd299, "R4 below lower ch9");
        rd_all("R4 R6 status readback");
        // R6 interrupt enable, flag write of one has no effect
        wr(4'd0, 8'h50, "R6 irq enable");
        wr(4'd8, 8'hFF, "R7 write ones no effect");
        wr(4'd7, 8'h00, "R7 clear ch0-7");
        rd_all("R7 after clear");
        wr(4'd0, 8'h10, "R7 clear flag");
        // R7 event wins over clear in same cycle
        step(1'b1, 4'd8, 8'h00, 1'b1, 4'd9, 10'd1000, "R7 event beats clear");
        wr(4'd8, 8'h00, "R7 clear ch9");
        step(1'b1, 4'd0, 8'h10, 1'b1, 4'd4, 10'd0, "R7 flag event beats clear");
        wr(4'd0, 8'h00, "R6 irq disable");
        wr(4'd7, 8'h00, "R7 clear ch4");
        wr(4'd0, 8'h00, "R7 clear flag again");
        // R1 low bits matter: upper 801
        wr(4'd2, 8'h01, "R1 upper low bits");
        res(4'd4, 10'd801, "R5 equal upper 801");
        res(4'd4, 10'd802, "R4 above upper 802");
        // R2 low bits: lower 303
        wr(4'd4, 8'h03, "R2 lower low bits");
        res(4'd9, 10'd303, "R5 equal lower 303");
        res(4'd9, 10'd302, "R4 below lower 302");
        rd_all("R1 R2 final readback");
        // R3 disable channel 9, then out-of-window result ignored
        wr(4'd8, 8'h00, "R7 clear ch9");
        wr(4'd6, 8'h00, "R3 disable ch9");
        res(4'd9, 10'd0, "R8 ch9 now disabled");
        rd_all("R8 final");
        @(negedge clk);
        finish_run();
    end
endmodule